// File: doc/BRIEF.md
# Pin-Change and External Interrupt Front End

This block sits between the general-purpose pins of a small microcontroller and its interrupt vector unit. It watches several banks of pins, eight pins to a bank. Whenever any pin that software has included in a bank's mask toggles in either direction, the block latches a per-bank flag. It also watches one dedicated external interrupt pin. That pin can be sensed on a low level, on any edge, on a falling edge or on a rising edge. The pin is observed purely as an input, so it raises requests even when other logic drives it as an output.

Each source has its own request line toward the vector unit. A request is qualified by that source's enable bit and by a global interrupt enable input. A latched flag is cleared when the vector unit acknowledges the source on handler entry, or when software writes a one to the flag bit. Software reaches the mask, enable, sense and flag registers over a simple synchronous register bus. Reads on that bus are combinational.

Every pin passes through a two-stage synchroniser before detection. A parameter can mark the upper banks as absent for reduced-pin parts. At most four banks are supported, because the flag layout has room for four.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset every register reads 0 and every request output is 0.
- R2: For a bank whose mask includes a pin, a rising or a falling change on that pin sets the bank flag. The bank flag is bit 4+g of the flag register at address 6. The flag is readable on the third rising clock edge after the pin changes.
- R3: The mask register of bank g is at address g, and bit i of it set to 1 includes pin i of that bank. A change on an excluded pin does not set the flag.
- R4: The request line of bank g is high exactly when that bank's flag is set, enable bit 4+g (address 4) is 1, and the global enable is 1.
- R5: Writing 1 to a flag bit clears it, and writing 0 to it leaves it unchanged. An acknowledge pulse on the source's acknowledge input also clears its flag.
- R6: When a new detection and a clear (a write of one, or an acknowledge) land on the same clock edge, the flag stays set.
- R7: The sense field is bits 1:0 of address 5, with 00 = low level, 01 = any edge, 10 = falling edge and 11 = rising edge. In the three edge modes, a matching edge of the external pin sets flag bit 0, and a non-matching edge does not set it.
- R8: In low-level mode, the external request equals (synchronised pin is 0) AND enable bit 0 AND global enable. It follows the pin two rising edges after a pin change, and flag bit 0 is not set.
- R9: Flag and enable bits 3:1 read as 0. For a bank at or above ACTIVE_GROUPS, the mask reads 0, the flag never sets and the request never rises.
- R10: A pin level that is present at reset release is not reported as a change, even when the masks and the sense mode are programmed in the first cycles after reset.
- R11: Mask registers, enable bits 7:4 and 0, and sense bits 1:0 read back the values written, and the unused sense bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie | input | 1 | Global interrupt enable |
| grp_pins | input | NUM_GROUPS*GROUP_W | Bank pins, bank g at bits g*GROUP_W and up |
| ext_pin | input | 1 | Dedicated external interrupt pin |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Combinational read data |
| grp_ack | input | NUM_GROUPS | Vector entry acknowledge, one per bank |
| ext_ack | input | 1 | Vector entry acknowledge for the external pin |
| grp_req | output | NUM_GROUPS | Request per bank |
| ext_req | output | 1 | External pin request |

## Verification
The bench targets the clear-versus-set collision by timing a write of one and an acknowledge to fall on the exact edge where a fresh change is detected. A design that lets the clear win would lose that event and read the flag as 0. It programs masks and the rising-edge sense mode in the first cycles after reset while the pins already sit high. A design with no warm-up would latch phantom flags from the still-empty synchroniser history. It also checks the three-edge latency cycle by cycle, edges of the wrong polarity in each edge mode, level mode leaving the flag alone, and a bank marked absent that must stay silent even with its mask and enable written to ones.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  localparam int REG_W        = 8;
  localparam int ADDR_W       = 3;
  localparam int FLAG_GRP_LSB = 4;
  localparam int EXT_BIT      = 0;

  localparam logic [ADDR_W-1:0] ADDR_EN    = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SENSE = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 3'd6;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // next flag value: a detection always beats a clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // edge match of the external pin for the selected mode
  function automatic logic edge_match(input sense_e mode, input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (mode)
      SENSE_ANY:  return rise | fall;
      SENSE_FALL: return fall;
      SENSE_RISE: return rise;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/pinirq_group.sv
module pinirq_group
  import pinirq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] mask,
  input  logic         clr,
  output logic         flag,
  output logic         hit
);
  logic [W-1:0] prev;
  logic         flag_q;

  assign hit  = arm & (|((pin_s ^ prev) & mask));
  assign flag = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= '0;
      flag_q <= 1'b0;
    end else begin
      prev   <= pin_s;
      flag_q <= flag_next(flag_q, hit, clr);
    end
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hit) |=> $stable(flag));
  p_arm_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !flag) |=> !flag);
endmodule

// File: rtl/pinirq_ext.sv
module pinirq_ext
  import pinirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   arm,
  input  logic   pin_s,
  input  sense_e sense,
  input  logic   clr,
  output logic   flag,
  output logic   edge_hit,
  output logic   level_act
);
  logic prev;
  logic flag_q;

  assign edge_hit  = arm & edge_match(sense, pin_s, prev);
  assign level_act = arm & (sense == SENSE_LOW) & ~pin_s;
  assign flag      = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev   <= pin_s;
      flag_q <= flag_next(flag_q, edge_hit, clr);
    end
  end

  p_level_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_LOW && !flag) |=> !flag);
  p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> flag);
  p_ext_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !flag);
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
#(
  parameter int NUM_GROUPS    = 4,
  parameter int GROUP_W       = 8,
  parameter int ACTIVE_GROUPS = 4,
  parameter int WARM_CYCLES   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          gie,
  input  logic [NUM_GROUPS*GROUP_W-1:0] grp_pins,
  input  logic                          ext_pin,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [REG_W-1:0]              bus_wdata,
  input  logic                          bus_we,
  output logic [REG_W-1:0]              bus_rdata,
  input  logic [NUM_GROUPS-1:0]         grp_ack,
  input  logic                          ext_ack,
  output logic [NUM_GROUPS-1:0]         grp_req,
  output logic                          ext_req
);
  localparam int PIN_W  = NUM_GROUPS * GROUP_W;
  localparam int SYNC_W = PIN_W + 1;
  localparam int WARM_W = $clog2(WARM_CYCLES + 1);

  // synchronised pins, external pin on top
  logic [SYNC_W-1:0] pins_s;
  pinirq_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ext_pin, grp_pins}), .q(pins_s)
  );

  // warm-up: detection waits until synchroniser and history hold real pin data
  logic [WARM_W-1:0] warm_cnt;
  logic              arm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       warm_cnt <= '0;
    else if (!arm)    warm_cnt <= warm_cnt + 1'b1;
  end
  assign arm = (warm_cnt == WARM_W'(WARM_CYCLES));

  // bus decode
  logic flag_wr, en_wr, sense_wr;
  assign flag_wr  = bus_we && (bus_addr == ADDR_FLAG);
  assign en_wr    = bus_we && (bus_addr == ADDR_EN);
  assign sense_wr = bus_we && (bus_addr == ADDR_SENSE);

  // enable and sense registers
  logic [NUM_GROUPS-1:0] grp_en_q;
  logic                  ext_en_q;
  sense_e                sense_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_en_q <= '0;
      ext_en_q <= 1'b0;
      sense_q  <= SENSE_LOW;
    end else begin
      if (en_wr) begin
        grp_en_q <= bus_wdata[FLAG_GRP_LSB +: NUM_GROUPS];
        ext_en_q <= bus_wdata[EXT_BIT];
      end
      if (sense_wr) sense_q <= sense_e'(bus_wdata[1:0]);
    end
  end

  // per-bank mask, detection and flag
  logic [GROUP_W-1:0]    mask_w [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grp_flag, grp_hit, grp_clr;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    if (g < ACTIVE_GROUPS) begin : g_live
      logic [GROUP_W-1:0] mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    mask_q <= '0;
        else if (bus_we && bus_addr == ADDR_W'(g))     mask_q <= bus_wdata[GROUP_W-1:0];
      end
      assign mask_w[g] = mask_q;
    end else begin : g_absent
      assign mask_w[g] = '0;
      p_absent_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_flag[g] && !grp_req[g]);
    end

    assign grp_clr[g] = (flag_wr & bus_wdata[FLAG_GRP_LSB + g]) | grp_ack[g];

    pinirq_group #(.W(GROUP_W)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (arm),
      .pin_s (pins_s[g*GROUP_W +: GROUP_W]),
      .mask  (mask_w[g]),
      .clr   (grp_clr[g]),
      .flag  (grp_flag[g]),
      .hit   (grp_hit[g])
    );
  end

  // external pin
  logic ext_flag, ext_hit, ext_level, ext_clr;
  assign ext_clr = (flag_wr & bus_wdata[EXT_BIT]) | ext_ack;

  pinirq_ext u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .pin_s     (pins_s[PIN_W]),
    .sense     (sense_q),
    .clr       (ext_clr),
    .flag      (ext_flag),
    .edge_hit  (ext_hit),
    .level_act (ext_level)
  );

  // requests
  assign grp_req = grp_flag & grp_en_q & {NUM_GROUPS{gie}};
  assign ext_req = gie & ext_en_q & ((sense_q == SENSE_LOW) ? ext_level : ext_flag);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_FLAG) begin
      bus_rdata[FLAG_GRP_LSB +: NUM_GROUPS] = grp_flag;
      bus_rdata[EXT_BIT]                    = ext_flag;
    end else if (bus_addr == ADDR_EN) begin
      bus_rdata[FLAG_GRP_LSB +: NUM_GROUPS] = grp_en_q;
      bus_rdata[EXT_BIT]                    = ext_en_q;
    end else if (bus_addr == ADDR_SENSE) begin
      bus_rdata[1:0] = sense_q;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++)
        if (bus_addr == ADDR_W'(g)) bus_rdata[GROUP_W-1:0] = mask_w[g];
    end
  end

  p_req_needs_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grp_req) || ext_req) |-> gie);
  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_FLAG || bus_addr == ADDR_EN) |-> (bus_rdata[3:1] == 3'b000));
  p_req_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_req & ~grp_flag) == '0);
  p_level_no_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_q == SENSE_LOW) |-> !ext_hit);
endmodule

// File: tb/tb_pinirq_ctrl.sv
module tb_pinirq_ctrl;
  localparam int CLK_P = 10;
  localparam int NG = 4;
  localparam int GW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gie = 1'b0;
  logic [NG*GW-1:0] pins = 32'hA5A5_5A5A;
  logic          ext_pin = 1'b1;
  logic [2:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic          we = 1'b0;
  logic [7:0]    rdata;
  logic [NG-1:0] gack = '0;
  logic          eack = 1'b0;
  logic [NG-1:0] greq;
  logic          ereq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pinirq_ctrl #(.NUM_GROUPS(NG), .GROUP_W(GW), .ACTIVE_GROUPS(3)) dut (
    .clk(clk), .rst_n(rst_n), .gie(gie), .grp_pins(pins), .ext_pin(ext_pin),
    .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata),
    .grp_ack(gack), .ext_ack(eack), .grp_req(greq), .ext_req(ereq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_warmup;
    logic [7:0] v;
    // pins already high and mixed at release; program at once (R10)
    @(negedge clk); rst_n = 1'b1;
    wr(3'd0, 8'hFF);
    wr(3'd5, 8'h03);
    wr(3'd1, 8'hFF);
    wait_n(6);
    rd(3'd6, v); chk("R10 no phantom flags after reset", v, 8'h00);
    chk("R1 requests idle", {greq, ereq}, 5'b0);
    rd(3'd2, v); chk("R1 mask2 reset value", v, 8'h00);
    rd(3'd4, v); chk("R1 enable reset value", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(3'd0, 8'h01); wr(3'd1, 8'h0F); wr(3'd2, 8'h3C); wr(3'd3, 8'hFF);
    rd(3'd0, v); chk("R11 mask0 readback", v, 8'h01);
    rd(3'd1, v); chk("R11 mask1 readback", v, 8'h0F);
    rd(3'd2, v); chk("R11 mask2 readback", v, 8'h3C);
    rd(3'd3, v); chk("R9 absent bank mask reads 0", v, 8'h00);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R9 R11 enable readback, bits 3:1 zero", v, 8'hF1);
    wr(3'd5, 8'hFE);
    rd(3'd5, v); chk("R11 sense readback", v, 8'h02);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_change_timing;
    logic [7:0] v;
    pins[0] = ~pins[0];
    wait_n(2);
    rd(3'd6, v); chk("R2 flag not yet after two edges", v, 8'h00);
    wait_n(1);
    rd(3'd6, v); chk("R2 flag set on third edge (rise/fall)", v, 8'h10);
    wr(3'd6, 8'h00);
    rd(3'd6, v); chk("R5 write 0 keeps flag", v, 8'h10);
    wr(3'd6, 8'h10);
    rd(3'd6, v); chk("R5 write 1 clears flag", v, 8'h00);
    pins[0] = ~pins[0];
    wait_n(4);
    rd(3'd6, v); chk("R2 opposite direction sets flag", v, 8'h10);
    wr(3'd6, 8'h10);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    pins[GW+7] = ~pins[GW+7];
    pins[5] = ~pins[5];
    wait_n(4);
    rd(3'd6, v); chk("R3 excluded pins ignored", v, 8'h00);
    pins[GW+2] = ~pins[GW+2];
    wait_n(4);
    rd(3'd6, v); chk("R3 included pin of bank 1 sets bit 5", v, 8'h20);
  endtask

  task automatic t_request;
    logic [7:0] v;
    gie = 1'b0;
    wr(3'd4, 8'h20);
    chk("R4 no request without global enable", greq, 4'b0000);
    gie = 1'b1; #1;
    chk("R4 request with flag, enable, global", greq, 4'b0010);
    wr(3'd4, 8'h10);
    chk("R4 request drops with bank enable", greq, 4'b0000);
    wr(3'd4, 8'h20);
    gack[1] = 1'b1; @(negedge clk); gack[1] = 1'b0;
    rd(3'd6, v); chk("R5 acknowledge clears flag", v, 8'h00);
    chk("R4 request falls after acknowledge", greq, 4'b0000);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    pins[0] = ~pins[0];
    wait_n(4);
    rd(3'd6, v); chk("R6 setup flag", v, 8'h10);
    pins[0] = ~pins[0];
    wait_n(2);
    wr(3'd6, 8'h10);
    rd(3'd6, v); chk("R6 set beats write-one clear", v, 8'h10);
    wr(3'd6, 8'h10);
    rd(3'd6, v); chk("R5 later clear works", v, 8'h00);
    pins[0] = ~pins[0];
    wait_n(4);
    pins[0] = ~pins[0];
    wait_n(2);
    gack[0] = 1'b1; @(negedge clk); gack[0] = 1'b0;
    rd(3'd6, v); chk("R6 set beats acknowledge", v, 8'h10);
    wr(3'd6, 8'h10);
  endtask

  task automatic t_absent;
    logic [7:0] v;
    wr(3'd4, 8'h80);
    pins[3*GW+1] = ~pins[3*GW+1];
    wait_n(4);
    rd(3'd6, v); chk("R9 absent bank flag stays 0", v, 8'h00);
    chk("R9 absent bank request stays 0", greq, 4'b0000);
  endtask

  task automatic t_ext_level;
    logic [7:0] v;
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h01);
    ext_pin = 1'b1; wait_n(3);
    chk("R8 high pin no request", ereq, 1'b0);
    ext_pin = 1'b0; wait_n(1);
    chk("R8 one edge later still low", ereq, 1'b0);
    wait_n(1);
    chk("R8 request follows low pin", ereq, 1'b1);
    rd(3'd6, v); chk("R8 no flag in level mode", v, 8'h00);
    ext_pin = 1'b1; wait_n(2);
    chk("R8 request released", ereq, 1'b0);
  endtask

  task automatic t_ext_edges;
    logic [7:0] v;
    wr(3'd5, 8'h03);
    ext_pin = 1'b0; wait_n(4);
    rd(3'd6, v); chk("R7 rising mode ignores fall", v, 8'h00);
    ext_pin = 1'b1; wait_n(4);
    rd(3'd6, v); chk("R7 rising edge sets flag", v, 8'h01);
    chk("R7 edge request", ereq, 1'b1);
    wr(3'd6, 8'h01);
    wr(3'd5, 8'h02);
    ext_pin = 1'b0; wait_n(4);
    rd(3'd6, v); chk("R7 falling edge sets flag", v, 8'h01);
    wr(3'd6, 8'h01);
    ext_pin = 1'b1; wait_n(4);
    rd(3'd6, v); chk("R7 falling mode ignores rise", v, 8'h00);
    wr(3'd5, 8'h01);
    ext_pin = 1'b0; wait_n(4);
    rd(3'd6, v); chk("R7 any edge: fall", v, 8'h01);
    eack = 1'b1; @(negedge clk); eack = 1'b0;
    rd(3'd6, v); chk("R5 external acknowledge clears", v, 8'h00);
    ext_pin = 1'b1; wait_n(4);
    rd(3'd6, v); chk("R7 any edge: rise", v, 8'h01);
  endtask

  initial begin
    wait_n(3);
    t_reset_warmup();
    t_regs();
    t_change_timing();
    t_mask();
    t_request();
    t_collision();
    t_absent();
    t_ext_level();
    t_ext_edges();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule